// File: doc/BRIEF.md
# Downstream Timing Superframe Framer with Half-Word Gearbox

This block assembles the continuous downstream timing stream that carries trigger decisions and commands to a tree of receiving nodes. On every slow-clock tick it builds one 32-bit word of the current superframe. A superframe is a comma byte followed by 64 four-byte subframes and one three-byte closing subframe, 65 words in all. The closing subframe carries the address of the node that may next use the shared upstream channel. That address moves round-robin over a configurable number of nodes, once per superframe.

A gearbox then splits each word into two 16-bit halves at the fast clock rate, with a per-byte K-character flag for the line encoder that follows. The first word of every superframe carries the comma. Loading it toggles a marker line, and the gearbox re-locks its half order to that marker. The first fast output after the marker is always the leading half. Latency from word load to line output is therefore fixed after any reset, whatever state the gearbox's own phase bit held. Both clock domains are modelled as one fast clock `clk` plus a half-rate enable `slowEn`.

Top module: `sfgen_top`

## Requirements
- R1: After reset the first word loaded (on the first cycle with `slowEn` high) is superframe word 0, and its first byte is the comma 0xBC. Each superframe is 65 words of 32 bits (260 bytes), one word per `slowEn` cycle, and word 0 of every superframe begins with the comma.
- R2: Subframe n (1..64) is sampled in word n-1. Its bytes go out in the order T (`trigType`), F (`auxByte`), D1, D2. T, F and D1 fill bytes 1..3 of word n-1, and D2 (`cmdTail`) becomes byte 0 of word n.
- R3: D1 is `{cmdLead[6:0], cmdDirected}`: bit 0 of D1 is 1 for a command aimed only at the node whose number equals the subframe index, and 0 for a broadcast.
- R4: Word 64 holds the closing subframe of three bytes: T, F, then the token byte R in place of D1.
- R5: After reset the first R is 1. Each later R is the previous R plus 1, and after the last node it wraps to 1.
- R6: The node count is `onuCount`, except that 0 is taken as 1 and any value above 64 is taken as 64.
- R7: If the previous R is not below the effective count (for example after `onuCount` was lowered), the next R is 1.
- R8: Each word goes out as two halves. Bytes 0 and 1 form the leading half, bytes 2 and 3 the trailing half, and the earlier byte of each pair sits in bits 15:8. The fast cycle right after a comma load always carries the leading half, and the halves then alternate.
- R9: The leading half of a comma word appears on `txHalf` at the fast edge right after the edge that loaded it.
- R10: From reset until the first comma half is output, `txHalf` and `txIsK` are zero.
- R11: `txIsK[1]` is high only together with 0xBC in `txHalf[15:8]`, and `txIsK[0]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| slowEn | input | 1 | Half-rate enable marking slow-clock ticks |
| trigType | input | 8 | Trigger type byte T |
| auxByte | input | 8 | Auxiliary byte F |
| cmdLead | input | 7 | Upper seven bits of command byte D1 |
| cmdDirected | input | 1 | 1 = addressed command, 0 = broadcast (D1 bit 0) |
| cmdTail | input | 8 | Command byte D2 |
| onuCount | input | 7 | Number of nodes in the token rotation |
| txHalf | output | 16 | Half-word toward the line encoder |
| txIsK | output | 2 | K-character flag per byte of `txHalf` |

## Verification
Two things happen on the same fast edge once per superframe. The gearbox puts out the trailing half of word 64, which holds the token byte, while the framer loads the comma word and toggles the re-lock marker. The bench runs unbroken superframes across this boundary and checks that the token half and the following comma half both arrive in order, with no slip. Resets are applied at varying offsets from `slowEn`. Each time, the cycle in which the comma first shows is compared against the load edge computed in the bench, and every byte of the following superframes is compared with values derived from the stimulus index.

// File: rtl/sfgen_pkg.sv
`timescale 1ns/1ps
package sfgen_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W = BYTE_W * WORD_BYTES;
  localparam int HALF_W = WORD_W / 2;
  localparam logic [BYTE_W-1:0] COMMA_CHAR = 8'hBC;

  typedef logic [BYTE_W-1:0] byte_t;

  // strobes from control to datapath
  typedef struct packed {
    logic  loadWord;
    logic  commaSlot;
    logic  tokenSlot;
    byte_t tokenAddr;
  } sfStrobe_t;
endpackage

// File: rtl/sfgen_ctrl.sv
`timescale 1ns/1ps
module sfgen_ctrl
  import sfgen_pkg::*;
#(
  parameter int SUBFRAMES = 65,
  parameter int MAX_ONU = 64,
  parameter int ONU_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slowEn,
  input  logic [ONU_W-1:0] onuCount,
  output sfStrobe_t        strobe
);
  localparam int CNT_W = $clog2(SUBFRAMES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SUBFRAMES - 1);

  logic [CNT_W-1:0] wordIdx;
  byte_t lastToken;
  byte_t effCount;
  byte_t nextToken;

  always_comb begin
    if (onuCount == '0)
      effCount = byte_t'(1);
    else if (int'(onuCount) > MAX_ONU)
      effCount = byte_t'(MAX_ONU);
    else
      effCount = byte_t'(onuCount);
    nextToken = (lastToken >= effCount) ? byte_t'(1) : lastToken + byte_t'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordIdx   <= '0;
      lastToken <= '0;
    end else if (slowEn) begin
      wordIdx <= (wordIdx == LAST_IDX) ? '0 : wordIdx + CNT_W'(1);
      if (wordIdx == LAST_IDX) lastToken <= nextToken;
    end
  end

  always_comb begin
    strobe.loadWord  = slowEn;
    strobe.commaSlot = (wordIdx == '0);
    strobe.tokenSlot = (wordIdx == LAST_IDX);
    strobe.tokenAddr = nextToken;
  end
endmodule

// File: rtl/sfgen_dpath.sv
`timescale 1ns/1ps
module sfgen_dpath
  import sfgen_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  sfStrobe_t             strobe,
  input  byte_t                 trigType,
  input  byte_t                 auxByte,
  input  logic [BYTE_W-2:0]     cmdLead,
  input  logic                  cmdDirected,
  input  byte_t                 cmdTail,
  output logic [WORD_W-1:0]     wordOut,
  output logic [WORD_BYTES-1:0] wordK,
  output logic                  kToggle
);
  byte_t heldTail;
  byte_t nextBytes [WORD_BYTES];
  byte_t wordBytes [WORD_BYTES];

  always_comb begin
    nextBytes[0] = strobe.commaSlot ? COMMA_CHAR : heldTail;
    nextBytes[1] = trigType;
    nextBytes[2] = auxByte;
    nextBytes[3] = strobe.tokenSlot ? strobe.tokenAddr : {cmdLead, cmdDirected};
  end

  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_bytes
    always_ff @(posedge clk) begin
      if (rst) wordBytes[i] <= '0;
      else if (strobe.loadWord) wordBytes[i] <= nextBytes[i];
    end
    // byte 0 lands in the most significant position
    assign wordOut[WORD_W-1-i*BYTE_W -: BYTE_W] = wordBytes[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      heldTail <= '0;
      wordK    <= '0;
      kToggle  <= 1'b0;
    end else if (strobe.loadWord) begin
      heldTail <= cmdTail;
      wordK    <= {strobe.commaSlot, {(WORD_BYTES-1){1'b0}}};
      kToggle  <= kToggle ^ strobe.commaSlot;
    end
  end
endmodule

// File: rtl/sfgen_gearbox.sv
`timescale 1ns/1ps
module sfgen_gearbox
  import sfgen_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WORD_W-1:0]     wordIn,
  input  logic [WORD_BYTES-1:0] wordK,
  input  logic                  kToggle,
  output logic [HALF_W-1:0]     txHalf,
  output logic [1:0]            txIsK
);
  localparam int HALF_BYTES = WORD_BYTES / 2;

  logic kSeen;
  logic locked;
  logic sendLow;
  logic [HALF_W-1:0]     halfData [2];
  logic [HALF_BYTES-1:0] halfK    [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign halfData[h] = wordIn[WORD_W-1-h*HALF_W -: HALF_W];
    assign halfK[h]    = wordK[WORD_BYTES-1-h*HALF_BYTES -: HALF_BYTES];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kSeen   <= 1'b0;
      locked  <= 1'b0;
      sendLow <= 1'b0;
      txHalf  <= '0;
      txIsK   <= '0;
    end else if (kToggle != kSeen) begin
      // first fast edge after a comma: leading half, by definition
      kSeen   <= kToggle;
      locked  <= 1'b1;
      sendLow <= 1'b1;
      txHalf  <= halfData[0];
      txIsK   <= halfK[0];
    end else if (locked) begin
      sendLow <= ~sendLow;
      txHalf  <= halfData[sendLow];
      txIsK   <= halfK[sendLow];
    end
  end
endmodule

// File: rtl/sfgen_top.sv
`timescale 1ns/1ps
module sfgen_top
  import sfgen_pkg::*;
#(
  parameter int SUBFRAMES = 65,
  parameter int MAX_ONU = 64,
  parameter int ONU_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slowEn,
  input  logic [7:0]       trigType,
  input  logic [7:0]       auxByte,
  input  logic [6:0]       cmdLead,
  input  logic             cmdDirected,
  input  logic [7:0]       cmdTail,
  input  logic [ONU_W-1:0] onuCount,
  output logic [15:0]      txHalf,
  output logic [1:0]       txIsK
);
  sfStrobe_t ctrlStrobe;
  logic [WORD_W-1:0]     wordBus;
  logic [WORD_BYTES-1:0] wordKBus;
  logic                  kToggle;

  sfgen_ctrl #(.SUBFRAMES(SUBFRAMES), .MAX_ONU(MAX_ONU), .ONU_W(ONU_W)) ctrl_i (
    .clk(clk), .rst(rst), .slowEn(slowEn), .onuCount(onuCount), .strobe(ctrlStrobe)
  );

  sfgen_dpath dpath_i (
    .clk(clk), .rst(rst), .strobe(ctrlStrobe),
    .trigType(trigType), .auxByte(auxByte), .cmdLead(cmdLead),
    .cmdDirected(cmdDirected), .cmdTail(cmdTail),
    .wordOut(wordBus), .wordK(wordKBus), .kToggle(kToggle)
  );

  sfgen_gearbox gear_i (
    .clk(clk), .rst(rst), .wordIn(wordBus), .wordK(wordKBus), .kToggle(kToggle),
    .txHalf(txHalf), .txIsK(txIsK)
  );
endmodule

// File: rtl/sfgen_checker.sv
`timescale 1ns/1ps
module sfgen_checker #(
  parameter int SUBFRAMES = 65,
  parameter int MAX_ONU = 64
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] txHalf,
  input logic [1:0]  txIsK,
  input logic        tokenSlot,
  input logic [7:0]  tokenAddr
);
  localparam int PERIOD = 2 * SUBFRAMES;

  logic [15:0] sinceK;
  logic        seenK;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceK <= '0;
      seenK  <= 1'b0;
    end else if (txIsK[1]) begin
      sinceK <= '0;
      seenK  <= 1'b1;
    end else begin
      sinceK <= sinceK + 16'd1;
    end
  end

  assert_k_is_comma_R11: assert property (@(posedge clk) disable iff (rst)
    txIsK[1] |-> txHalf[15:8] == 8'hBC);

  assert_k_low_clear_R11: assert property (@(posedge clk) disable iff (rst)
    txIsK[0] == 1'b0);

  // comma half is followed by the trailing half of the same word
  assert_half_alternate_R8: assert property (@(posedge clk) disable iff (rst)
    txIsK[1] |=> !txIsK[1]);

  // counter-based window: commas are one superframe apart
  assert_comma_period_R1: assert property (@(posedge clk) disable iff (rst)
    (seenK && txIsK[1]) |-> sinceK == 16'(PERIOD - 1));

  assert_token_range_R6: assert property (@(posedge clk) disable iff (rst)
    tokenSlot |-> (tokenAddr >= 8'd1 && int'(tokenAddr) <= MAX_ONU));
endmodule

bind sfgen_top sfgen_checker #(.SUBFRAMES(SUBFRAMES), .MAX_ONU(MAX_ONU)) chk_i (
  .clk(clk), .rst(rst), .txHalf(txHalf), .txIsK(txIsK),
  .tokenSlot(ctrlStrobe.tokenSlot), .tokenAddr(ctrlStrobe.tokenAddr)
);

// File: tb/sfgen_top_tb.sv
`timescale 1ns/1ps
module sfgen_top_tb_top;
  localparam int SF = 65;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slowEn = 1'b0;
  logic [7:0] trigType = '0, auxByte = '0, cmdTail = '0;
  logic [6:0] cmdLead = '0, onuCount = 7'd3;
  logic cmdDirected = 1'b0;
  logic [15:0] txHalf;
  logic [1:0]  txIsK;

  int total = 0, bad = 0;
  int g = 0, p = 0, sinceRel = 0, firstLoad = -1, lastTok = 0;
  bit locked = 0, relPending = 0;

  always #5 clk = ~clk;

  sfgen_top dut_i (
    .clk(clk), .rst(rst), .slowEn(slowEn), .trigType(trigType), .auxByte(auxByte),
    .cmdLead(cmdLead), .cmdDirected(cmdDirected), .cmdTail(cmdTail),
    .onuCount(onuCount), .txHalf(txHalf), .txIsK(txIsK)
  );

  function automatic logic [7:0] fTrig(int k); return 8'(k * 7 + 3); endfunction
  function automatic logic [7:0] fAux(int k);  return 8'(k ^ 32'h5A); endfunction
  function automatic logic [6:0] fLead(int k); return 7'(k * 3); endfunction
  function automatic logic fDir(int k);        return k[0] ^ k[3]; endfunction
  function automatic logic [7:0] fTail(int k); return 8'(k * 11 + 1); endfunction

  function automatic int effN();
    if (onuCount == 0) return 1;
    if (onuCount > 64) return 64;
    return int'(onuCount);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic monitor();
    logic [15:0] expH;
    logic [1:0]  expK;
    int w, slot, nt;
    if (!locked) begin
      if (txIsK == 2'b10) begin
        locked = 1;
        chk(sinceRel == firstLoad + 2, "R9 comma latency", 32'(sinceRel), 32'(firstLoad + 2));
        chk(txHalf == {8'hBC, fTrig(0)}, "R1 first word after reset", {16'd0, txHalf}, {16'd0, 8'hBC, fTrig(0)});
        p = 2;
      end else begin
        chk(txHalf == 16'd0 && txIsK == 2'b00, "R10 idle before comma", {14'd0, txIsK, txHalf}, 32'd0);
      end
      return;
    end
    w = p / 4;
    slot = w % SF;
    if (p % 4 == 0) begin
      expH = {(slot == 0) ? 8'hBC : fTail(w - 1), fTrig(w)};
      expK = {slot == 0, 1'b0};
      chk(txHalf == expH && txIsK == expK, (slot == 0) ? "R1 comma half" : "R2 R8 leading half",
          {14'd0, txIsK, txHalf}, {14'd0, expK, expH});
    end else if (slot == SF - 1) begin
      nt = (lastTok >= effN()) ? 1 : lastTok + 1;
      expH = {fAux(w), 8'(nt)};
      chk(txHalf == expH && txIsK == 2'b00, "R4 R5 R6 R7 token half",
          {14'd0, txIsK, txHalf}, {16'd0, expH});
      lastTok = nt;
    end else begin
      expH = {fAux(w), fLead(w), fDir(w)};
      chk(txHalf == expH && txIsK == 2'b00, "R3 R8 trailing half",
          {14'd0, txIsK, txHalf}, {16'd0, expH});
    end
    p += 2;
  endtask

  task automatic step();
    @(negedge clk);
    if (relPending) begin
      rst = 1'b0; relPending = 0;
      g = 0; p = 0; locked = 0; lastTok = 0; sinceRel = 0; firstLoad = -1;
    end else if (!rst) begin
      sinceRel++;
    end
    if (!rst) monitor();
    slowEn = ~slowEn;
    if (slowEn && !rst) begin
      trigType = fTrig(g); auxByte = fAux(g); cmdLead = fLead(g);
      cmdDirected = fDir(g); cmdTail = fTail(g);
      if (g == 0) firstLoad = sinceRel;
      g++;
    end
  endtask

  task automatic doReset(int hold);
    rst = 1'b1;
    repeat (hold) step();
    relPending = 1;
  endtask

  task automatic runSf(int n);
    repeat (n * 2 * SF + 4) step();
  endtask

  initial begin
    onuCount = 7'd3; doReset(3); runSf(6);            // R5 wrap at 3
    onuCount = 7'd1;
    for (int k = 0; k < 4; k++) begin                  // R9 R10 resets at varied phases
      repeat (37 * k + 11) step();
      doReset(2 + k);
      runSf(2);
    end
    onuCount = 7'd0;   doReset(2); runSf(2);          // R6 zero taken as one
    onuCount = 7'd100; doReset(3); runSf(66);         // R6 clamp to 64
    onuCount = 7'd64;  doReset(2); runSf(66);         // R5 full rotation
    onuCount = 7'd10;  doReset(4);                    // R7 shrink below token
    while (lastTok != 8) step();
    onuCount = 7'd4;
    runSf(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule